// File: doc/BRIEF.md
# Dual-list readout command sequencer

This block produces the ordered stream of dataway command words used to read out one event. Each command word packs a crate number, a station number, a subaddress and a function code. Event control issues a sequence of calls. Each call is a header word, and the block answers each header with exactly 64 command words.

One bit of the header picks the source of the 64 commands. When the bit is set, every command is a copy of one configured word, normally a read of the data stack. When the bit is clear, the commands come in order from a 64-entry programmable table that holds the addresses of the associated devices, such as time digitisers and pattern registers. The low bits of the header are a call number. That number travels with every command as a tag.

Calls can be chained to extend the channel count. Four stacked calls followed by one table call give 256 stacked channels plus 64 device reads. Two stacked calls followed by one table call cover a 192-channel array. A host port loads the table and the configured word.

Top module: `rdo_cmd_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `cmd_valid_o` and `done_o` are low and `hdr_ready_o` is high.
- R2: A header is taken on a clock edge where `hdr_valid_i` and `hdr_ready_o` are both high. Only bit 7 (the source bit) and bits 4:0 (the call number) are decoded, and bits 6:5 are ignored. In the cycle after the header is taken, `cmd_valid_o` is high and `cmd_idx_o` is 0.
- R3: When the source bit is 1, all 64 commands of the call equal the configured word.
- R4: When the source bit is 0, command k (for k = 0 to 63) equals table entry k, and `cmd_idx_o` reads k while that command is presented.
- R5: A command advances only on a clock edge where `cmd_valid_o` and `cmd_ready_i` are both high. While `cmd_ready_i` is low, `cmd_o`, `cmd_idx_o` and `cmd_tag_o` stay unchanged.
- R6: A call delivers exactly 64 commands. `done_o` is high for exactly one cycle, the cycle after the 64th accepted command. In that cycle `cmd_valid_o` is low and `hdr_ready_o` is high.
- R7: `cmd_tag_o` equals the call number of the header for the whole of its call.
- R8: A pulse on `host_list_we_i` writes `host_wdata_i` into table entry `host_idx_i`. A pulse on `host_fix_we_i` loads the configured word. Headers offered while a call is running are not taken.
- R9: Headers 25 to 28 with the source bit at 1, followed by header 29 with the bit at 0, give 256 configured-word commands and then the 64 table commands, each tagged with its own header number. The chain 25, 26 (bit at 1) followed by 27 (bit at 0) gives 128 plus 64 commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_list_we_i | input | 1 | Write strobe for a table entry |
| host_fix_we_i | input | 1 | Write strobe for the configured word |
| host_idx_i | input | 6 | Table index for a write |
| host_wdata_i | input | 17 | Write data: {crate[2:0], station[4:0], sub[3:0], func[4:0]} |
| hdr_valid_i | input | 1 | A header is offered |
| hdr_i | input | 8 | Header word: bit 7 is the source bit, bits 4:0 are the call number |
| hdr_ready_o | output | 1 | High when the block is idle and can take a header |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_ready_i | input | 1 | Downstream takes the command |
| cmd_o | output | 17 | Command word |
| cmd_idx_o | output | 6 | Position of the command within the call |
| cmd_tag_o | output | 5 | Call number of the running call |
| done_o | output | 1 | One-cycle pulse after the last command of a call |

## Verification
A wrong step counter or a wrong latched source bit shows up at the next accepted command. The bench sees it as a mismatch in `cmd_o` or `cmd_idx_o` within one cycle. A wrong end-of-call count does not show until the call ends. It then appears as a missing or misplaced `done_o`, or as a 65th command, in the cycle after the 64th handshake. Corrupted table storage is seen only when the corrupted entry is read. For that reason every table entry is compared on every table call, under random back-pressure.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int unsigned CRATE_W    = 3;
  localparam int unsigned STN_W      = 5;
  localparam int unsigned SUB_W      = 4;
  localparam int unsigned FN_W       = 5;
  localparam int unsigned CMD_W      = CRATE_W + STN_W + SUB_W + FN_W;
  localparam int unsigned LIST_DEPTH = 64;
  localparam int unsigned IDX_W      = $clog2(LIST_DEPTH);
  localparam int unsigned HDR_W      = 8;
  localparam int unsigned TAG_W      = 5;
  localparam int unsigned SEL_BIT    = 7;

  typedef struct packed {
    logic [CRATE_W-1:0] crate;
    logic [STN_W-1:0]   station;
    logic [SUB_W-1:0]   sub;
    logic [FN_W-1:0]    func;
  } cmd_t;

  typedef enum logic {
    SRC_LIST  = 1'b0,
    SRC_FIXED = 1'b1
  } src_e;
endpackage

// File: rtl/rdo_hdr_decode.sv
module rdo_hdr_decode #(
  parameter int unsigned HDR_W   = rdo_pkg::HDR_W,
  parameter int unsigned TAG_W   = rdo_pkg::TAG_W,
  parameter int unsigned SEL_BIT = rdo_pkg::SEL_BIT
) (
  input  logic [HDR_W-1:0] hdr_i,
  output rdo_pkg::src_e    src_o,
  output logic [TAG_W-1:0] tag_o
);
  assign src_o = rdo_pkg::src_e'(hdr_i[SEL_BIT]);
  assign tag_o = hdr_i[TAG_W-1:0];
endmodule

// File: rtl/rdo_cmd_store.sv
module rdo_cmd_store #(
  parameter int unsigned CMD_W      = rdo_pkg::CMD_W,
  parameter int unsigned LIST_DEPTH = rdo_pkg::LIST_DEPTH,
  localparam int unsigned IDX_W     = $clog2(LIST_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             list_we_i,
  input  logic             fix_we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CMD_W-1:0] wdata_i,
  input  rdo_pkg::src_e    rd_src_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CMD_W-1:0] rd_cmd_o
);
  logic [CMD_W-1:0] fixed_q;
  logic [CMD_W-1:0] list_q [LIST_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fixed_q <= '0;
    else if (fix_we_i) fixed_q <= wdata_i;
  end

  for (genvar g = 0; g < LIST_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       list_q[g] <= '0;
      else if (list_we_i && wr_idx_i == IDX_W'(g))       list_q[g] <= wdata_i;
    end
  end

  always_comb begin
    if (rd_src_i == rdo_pkg::SRC_FIXED) rd_cmd_o = fixed_q;
    else                                rd_cmd_o = list_q[rd_idx_i];
  end
endmodule

// File: rtl/rdo_step_ctrl.sv
module rdo_step_ctrl #(
  parameter int unsigned LIST_DEPTH = rdo_pkg::LIST_DEPTH,
  parameter int unsigned TAG_W      = rdo_pkg::TAG_W,
  localparam int unsigned IDX_W     = $clog2(LIST_DEPTH),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LIST_DEPTH - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  rdo_pkg::src_e    hdr_src_i,
  input  logic [TAG_W-1:0] hdr_tag_i,
  output logic             hdr_ready_o,
  input  logic             cmd_ready_i,
  output logic             busy_o,
  output rdo_pkg::src_e    src_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  rdo_pkg::src_e    src_q;
  logic             take_hdr, fire, last;

  assign take_hdr = hdr_valid_i && !busy_q;
  assign fire     = busy_q && cmd_ready_i;
  assign last     = (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      tag_q  <= '0;
      src_q  <= rdo_pkg::SRC_LIST;
    end else begin
      done_q <= fire && last;
      if (take_hdr) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        tag_q  <= hdr_tag_i;
        src_q  <= hdr_src_i;
      end else if (fire) begin
        idx_q <= idx_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign hdr_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign src_o       = src_q;
  assign idx_o       = idx_q;
  assign tag_o       = tag_q;
  assign done_o      = done_q;
endmodule

// File: rtl/rdo_cmd_seq.sv
module rdo_cmd_seq #(
  parameter int unsigned CMD_W      = rdo_pkg::CMD_W,
  parameter int unsigned LIST_DEPTH = rdo_pkg::LIST_DEPTH,
  parameter int unsigned HDR_W      = rdo_pkg::HDR_W,
  parameter int unsigned TAG_W      = rdo_pkg::TAG_W,
  parameter int unsigned SEL_BIT    = rdo_pkg::SEL_BIT,
  localparam int unsigned IDX_W     = $clog2(LIST_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_list_we_i,
  input  logic             host_fix_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic [CMD_W-1:0] host_wdata_i,
  input  logic             hdr_valid_i,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             hdr_ready_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [IDX_W-1:0] cmd_idx_o,
  output logic [TAG_W-1:0] cmd_tag_o,
  output logic             done_o
);
  rdo_pkg::src_e    dec_src, run_src;
  logic [TAG_W-1:0] dec_tag;
  logic [IDX_W-1:0] run_idx;

  rdo_hdr_decode #(.HDR_W(HDR_W), .TAG_W(TAG_W), .SEL_BIT(SEL_BIT)) u_dec (
    .hdr_i (hdr_i),
    .src_o (dec_src),
    .tag_o (dec_tag)
  );

  rdo_step_ctrl #(.LIST_DEPTH(LIST_DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_valid_i (hdr_valid_i),
    .hdr_src_i   (dec_src),
    .hdr_tag_i   (dec_tag),
    .hdr_ready_o (hdr_ready_o),
    .cmd_ready_i (cmd_ready_i),
    .busy_o      (cmd_valid_o),
    .src_o       (run_src),
    .idx_o       (run_idx),
    .tag_o       (cmd_tag_o),
    .done_o      (done_o)
  );

  rdo_cmd_store #(.CMD_W(CMD_W), .LIST_DEPTH(LIST_DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .list_we_i (host_list_we_i),
    .fix_we_i  (host_fix_we_i),
    .wr_idx_i  (host_idx_i),
    .wdata_i   (host_wdata_i),
    .rd_src_i  (run_src),
    .rd_idx_i  (run_idx),
    .rd_cmd_o  (cmd_o)
  );

  assign cmd_idx_o = run_idx;
endmodule

// File: rtl/rdo_cmd_seq_chk.sv
module rdo_cmd_seq_chk #(
  parameter int unsigned CMD_W      = rdo_pkg::CMD_W,
  parameter int unsigned LIST_DEPTH = rdo_pkg::LIST_DEPTH,
  parameter int unsigned HDR_W      = rdo_pkg::HDR_W,
  parameter int unsigned TAG_W      = rdo_pkg::TAG_W,
  localparam int unsigned IDX_W     = $clog2(LIST_DEPTH),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LIST_DEPTH - 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdr_valid_i,
  input logic [HDR_W-1:0] hdr_i,
  input logic             hdr_ready_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic [IDX_W-1:0] cmd_idx_o,
  input logic [TAG_W-1:0] cmd_tag_o,
  input logic             done_o
);
  // R2
  accept_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && hdr_ready_o |=> cmd_valid_o && cmd_idx_o == '0
                                   && cmd_tag_o == $past(hdr_i[TAG_W-1:0]));
  // R4
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && cmd_idx_o != LAST |=>
      cmd_valid_o && cmd_idx_o == $past(cmd_idx_o) + 1'b1);
  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=>
      cmd_valid_o && $stable(cmd_o) && $stable(cmd_idx_o) && $stable(cmd_tag_o));
  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && cmd_idx_o == LAST |=>
      done_o && !cmd_valid_o && hdr_ready_o);
  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !(cmd_ready_i && cmd_idx_o == LAST) |=> $stable(cmd_tag_o));
  // R8
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !hdr_ready_o);
endmodule

bind rdo_cmd_seq rdo_cmd_seq_chk #(
  .CMD_W(CMD_W), .LIST_DEPTH(LIST_DEPTH), .HDR_W(HDR_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/rdo_cmd_seq_bench.sv
module rdo_cmd_seq_bench;
  localparam int CMD_W = rdo_pkg::CMD_W;
  localparam int DEPTH = rdo_pkg::LIST_DEPTH;
  localparam int IDX_W = rdo_pkg::IDX_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             host_list_we_i = 1'b0, host_fix_we_i = 1'b0;
  logic [IDX_W-1:0] host_idx_i = '0;
  logic [CMD_W-1:0] host_wdata_i = '0;
  logic             hdr_valid_i = 1'b0;
  logic [7:0]       hdr_i = '0;
  logic             hdr_ready_o, cmd_valid_o, done_o;
  logic             cmd_ready_i = 1'b0;
  logic [CMD_W-1:0] cmd_o;
  logic [IDX_W-1:0] cmd_idx_o;
  logic [4:0]       cmd_tag_o;

  int checks = 0, fails = 0;
  int n_fixed = 0, n_list = 0;
  logic [CMD_W-1:0] fixed_m;
  logic [CMD_W-1:0] list_m [DEPTH];

  always #2 clk_i = ~clk_i;

  rdo_cmd_seq u_rdo_cmd_seq (.*);

  function automatic logic [CMD_W-1:0] exp_cmd(input logic src, input int k);
    return src ? fixed_m : list_m[k];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_list(input int idx, input logic [CMD_W-1:0] d);
    @(negedge clk_i);
    host_list_we_i = 1'b1; host_idx_i = IDX_W'(idx); host_wdata_i = d;
    list_m[idx] = d;
    @(negedge clk_i);
    host_list_we_i = 1'b0;
  endtask

  task automatic host_fix(input logic [CMD_W-1:0] d);
    @(negedge clk_i);
    host_fix_we_i = 1'b1; host_wdata_i = d; fixed_m = d;
    @(negedge clk_i);
    host_fix_we_i = 1'b0;
  endtask

  // one call: header, 64 commands under back-pressure, done pulse
  task automatic run_call(input logic src, input logic [4:0] tag, input int rdy_pct);
    int n;
    @(negedge clk_i);
    check(hdr_ready_o === 1'b1, "R2 ready before header", hdr_ready_o, 1);
    hdr_valid_i = 1'b1;
    hdr_i = {src, 2'($urandom), tag};
    @(negedge clk_i);
    n = 0;
    while (n < DEPTH) begin
      // stray header while busy must be ignored
      hdr_valid_i = ($urandom % 4) == 0;
      hdr_i = 8'($urandom);
      cmd_ready_i = ($urandom % 100) < 32'(rdy_pct);
      check(cmd_valid_o === 1'b1, "R5 valid during call", cmd_valid_o, 1);
      check(hdr_ready_o === 1'b0, "R8 header refused while busy", hdr_ready_o, 0);
      check(cmd_idx_o == IDX_W'(n), src ? "R3 index" : "R4 index", cmd_idx_o, n);
      check(cmd_o == exp_cmd(src, n), src ? "R3 fixed command" : "R4 table command",
            cmd_o, exp_cmd(src, n));
      check(cmd_tag_o == tag, "R7 tag", cmd_tag_o, tag);
      if (cmd_ready_i) begin
        n++;
        if (src) n_fixed++; else n_list++;
      end
      @(negedge clk_i);
    end
    hdr_valid_i = 1'b0;
    cmd_ready_i = 1'b0;
    check(done_o === 1'b1, "R6 done after 64th", done_o, 1);
    check(cmd_valid_o === 1'b0, "R6 no 65th command", cmd_valid_o, 0);
    check(hdr_ready_o === 1'b1, "R6 ready at done", hdr_ready_o, 1);
    @(negedge clk_i);
    check(done_o === 1'b0, "R6 done single cycle", done_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20931));
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check(cmd_valid_o === 1'b0 && done_o === 1'b0 && hdr_ready_o === 1'b1,
          "R1 reset state", {cmd_valid_o, done_o, hdr_ready_o}, 3'b001);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cmd_valid_o === 1'b0 && done_o === 1'b0 && hdr_ready_o === 1'b1,
          "R1 after release", {cmd_valid_o, done_o, hdr_ready_o}, 3'b001);

    // R8 load storage
    host_fix({3'd1, 5'd23, 4'd0, 5'd2});
    for (int i = 0; i < DEPTH; i++) host_list(i, CMD_W'($urandom));
    // no header -> no commands
    repeat (3) begin
      @(negedge clk_i);
      check(cmd_valid_o === 1'b0, "R2 idle without header", cmd_valid_o, 0);
    end

    // R9 maximum chain, full readiness
    n_fixed = 0; n_list = 0;
    for (int h = 25; h <= 28; h++) run_call(1'b1, 5'(h), 100);
    run_call(1'b0, 5'd29, 100);
    check(n_fixed == 256, "R9 stacked count", n_fixed, 256);
    check(n_list == 64, "R9 table count", n_list, 64);

    // R9 192-channel chain, back-pressure
    n_fixed = 0; n_list = 0;
    run_call(1'b1, 5'd25, 60);
    run_call(1'b1, 5'd26, 60);
    run_call(1'b0, 5'd27, 60);
    check(n_fixed == 128, "R9 192 stacked count", n_fixed, 128);
    check(n_list == 64, "R9 192 table count", n_list, 64);

    // R8 rewrite edges and the fixed word, then heavy stall
    host_list(0, CMD_W'(17'h1ffff));
    host_list(63, CMD_W'(17'h00001));
    host_fix(CMD_W'(17'h0a5a5));
    run_call(1'b0, 5'd0, 20);
    run_call(1'b1, 5'd31, 20);

    // random calls
    for (int c = 0; c < 12; c++) begin
      if ($urandom % 2) host_list(int'($urandom % DEPTH), CMD_W'($urandom));
      if ($urandom % 4 == 0) host_fix(CMD_W'($urandom));
      run_call(1'($urandom), 5'($urandom), 30 + int'($urandom % 70));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule